// File: doc/BRIEF.md
# Protected Instruction Format Checker

This block sits beside the instruction decoder and screens every decoded instruction before it reaches execution. A small group of system-level instructions (software reset, watchdog disable, watchdog service, end of initialisation, idle and power down) is guarded by a redundant four-byte encoding. The second byte must be the bitwise inverse of the first byte. The third and fourth bytes must both repeat the first byte. An instruction that keeps this rule gets a one-cycle execute enable on its own line. One whose first byte names a guarded instruction but whose other bytes break the rule sets a sticky protection-fault flag and raises a trap request. The captured return address is the address of the faulty instruction.

The same stage also spots opcodes that the machine does not implement. An unimplemented first byte sets a sticky undefined-opcode flag and raises the trap request, again capturing the instruction's own address. A trap handler can then inspect or emulate the instruction. Software clears each sticky flag through a write-one-to-clear strobe. The first bytes of the five guarded instructions other than software reset, and the map of unimplemented opcodes, are parameters. The inverse bytes are derived from them.

Top module: `prot_insn_check`

## Requirements
- R1: When `ins_valid` is high and the first byte equals a guarded code, the second byte equals its bitwise inverse and the third and fourth bytes equal the first byte, exactly one bit of `exec_en` is high in the next cycle for one cycle. The bit order is 0 reset, 1 watchdog disable, 2 watchdog service, 3 end of initialisation, 4 idle, 5 power down. With the default codes A5h, A7h, B5h, 87h and 97h for bits 1 to 5, no trap is raised in this case.
- R2: The software reset instruction B7h 48h B7h B7h drives `exec_en` bit 0.
- R3: A guarded first byte whose second byte is not its inverse raises `trap_req` for one cycle in the next cycle. It also sets `flag_prot`, leaves `flag_undef` clear and keeps `exec_en` at zero.
- R4: A guarded first byte whose third or fourth byte differs from the first byte is treated as in R3.
- R5: With every trap, `trap_ret_addr` takes the `ins_addr` of the trapping instruction in the same cycle as `trap_req`. It holds that value until the next trap.
- R6: A first byte that is not guarded and is marked in the unimplemented map raises `trap_req` and sets `flag_undef`, whatever the other bytes hold. The default map marks every byte whose low nibble is Fh and whose top bit is 1.
- R7: A first byte that is neither guarded nor unimplemented produces no enable, no trap and no flag, even when its other bytes follow the guarded pattern.
- R8: While `ins_valid` is low, the bytes and address are ignored: `exec_en`, `trap_req`, the flags and `trap_ret_addr` do not change.
- R9: Both flags stay set until cleared. `flag_clr` bit 0 clears `flag_prot` and bit 1 clears `flag_undef`. A new setting event in the same cycle as a clear wins.
- R10: After reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ins_valid | input | 1 | Decoded instruction present this cycle |
| ins_byte1 | input | 8 | First instruction byte (opcode) |
| ins_byte2 | input | 8 | Second instruction byte |
| ins_byte3 | input | 8 | Third instruction byte |
| ins_byte4 | input | 8 | Fourth instruction byte |
| ins_addr | input | ADDR_W | Address of the decoded instruction |
| flag_clr | input | 2 | Write-one-to-clear: bit 0 protection flag, bit 1 undefined flag |
| exec_en | output | 6 | One-cycle execute enable per guarded instruction |
| trap_req | output | 1 | One-cycle trap request |
| trap_ret_addr | output | ADDR_W | Return address for the trap handler |
| flag_prot | output | 1 | Sticky protection-fault flag |
| flag_undef | output | 1 | Sticky undefined-opcode flag |

## Verification
Every result is registered once. `exec_en`, `trap_req`, `trap_ret_addr` and a newly set flag all appear after the first rising edge that samples `ins_valid` high. A clear takes effect after the edge that samples `flag_clr`. The bench changes inputs on falling edges and reads outputs on the next falling edge, exactly one register stage later. It reads before it removes the stimulus, so the one-cycle pulses are caught. To check that nothing happens, it holds inputs for several cycles and confirms that the outputs stay where they were.

// File: rtl/prot_insn_pkg.sv
// Shared types and helpers for the protected-instruction checker.
// Assumes byte 1 of an instruction is the opcode byte.
package prot_insn_pkg;

    localparam int BYTE_W   = 8;
    localparam int PROT_NUM = 6;
    localparam int MAP_W    = 1 << BYTE_W;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef struct packed {
        byte_t b1;
        byte_t b2;
        byte_t b3;
        byte_t b4;
    } insn_word_t;

    // Default unimplemented map: top bit set and low nibble all ones.
    function automatic logic [MAP_W-1:0] default_undef_map();
        logic [MAP_W-1:0] m;
        m = '0;
        for (int i = 0; i < MAP_W; i++) begin
            m[i] = (i[3:0] == 4'hF) && i[7];
        end
        return m;
    endfunction

endpackage

// File: rtl/prot_slot_match.sv
// One guarded-instruction slot: hit means the opcode byte names this slot,
// ok means the full redundant encoding is also intact.
// Assumes CODE is unique among the slots.
module prot_slot_match
    import prot_insn_pkg::*;
#(
    parameter byte_t CODE = 8'hB7
) (
    input  insn_word_t word,
    output logic       hit,
    output logic       ok
);
    localparam byte_t CODE_INV = ~CODE;

    logic inv_good;
    logic rep_good;

    // Compare byte 2 against the derived inverse, bytes 3 and 4 against byte 1.
    always_comb begin
        hit      = (word.b1 == CODE);
        inv_good = (word.b2 == CODE_INV);
        rep_good = (word.b3 == CODE) && (word.b4 == CODE);
        ok       = hit && inv_good && rep_good;
    end
endmodule

// File: rtl/prot_opcode_class.sv
// Classifies one instruction word: per-slot good encodings, a guarded
// opcode with a broken encoding, or an unimplemented opcode.
// Assumes guarded codes are distinct; guarded codes take precedence over the map.
module prot_opcode_class
    import prot_insn_pkg::*;
#(
    parameter int                          NSLOT     = PROT_NUM,
    parameter logic [NSLOT*BYTE_W-1:0]     CODES     = '0,
    parameter logic [MAP_W-1:0]            UNDEF_MAP = default_undef_map()
) (
    input  insn_word_t       word,
    output logic [NSLOT-1:0] exec_vec,
    output logic             prot_bad,
    output logic             undef_op
);
    logic [NSLOT-1:0] hit_vec;
    logic [NSLOT-1:0] ok_vec;

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        prot_slot_match #(
            .CODE(CODES[s*BYTE_W +: BYTE_W])
        ) i_slot (
            .word(word),
            .hit (hit_vec[s]),
            .ok  (ok_vec[s])
        );
    end

    // Merge slot results into enables and the two fault classes.
    always_comb begin
        exec_vec = ok_vec;
        prot_bad = (|hit_vec) && !(|ok_vec);
        undef_op = !(|hit_vec) && UNDEF_MAP[word.b1];
    end
endmodule

// File: rtl/prot_trap_regs.sv
// Output register stage: execute pulses, trap pulse, return address
// capture and sticky fault flags with write-one-to-clear.
// Assumes exec_vec, prot_bad and undef_op are mutually exclusive.
module prot_trap_regs #(
    parameter int NSLOT  = 6,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ins_valid,
    input  logic [NSLOT-1:0]  exec_vec,
    input  logic              prot_bad,
    input  logic              undef_op,
    input  logic [ADDR_W-1:0] ins_addr,
    input  logic [1:0]        flag_clr,
    output logic [NSLOT-1:0]  exec_en,
    output logic              trap_req,
    output logic [ADDR_W-1:0] trap_ret_addr,
    output logic              flag_prot,
    output logic              flag_undef
);
    logic trap_now;

    // A trap is taken for any valid instruction in either fault class.
    always_comb trap_now = ins_valid && (prot_bad || undef_op);

    // Execute enable pulse for a well-formed guarded instruction.
    always_ff @(posedge clk) begin
        if (!rst_n) exec_en <= '0;
        else        exec_en <= ins_valid ? exec_vec : '0;
    end

    // Trap request pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) trap_req <= 1'b0;
        else        trap_req <= trap_now;
    end

    // Capture the faulting instruction's own address as the return address.
    always_ff @(posedge clk) begin
        if (!rst_n)        trap_ret_addr <= '0;
        else if (trap_now) trap_ret_addr <= ins_addr;
    end

    // Sticky flags; a new event wins over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_prot  <= 1'b0;
            flag_undef <= 1'b0;
        end else begin
            flag_prot  <= (flag_prot  && !flag_clr[0]) || (ins_valid && prot_bad);
            flag_undef <= (flag_undef && !flag_clr[1]) || (ins_valid && undef_op);
        end
    end

    AST_EXEC_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(exec_en)); // R1
    AST_TRAP_NO_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> (exec_en == '0)); // R3
    AST_TRAP_HAS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> (flag_prot || flag_undef)); // R6
    AST_RET_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        ins_valid && (prot_bad || undef_op) |=> (trap_ret_addr == $past(ins_addr))); // R5
    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !ins_valid |=> (!trap_req && exec_en == '0 && $stable(trap_ret_addr))); // R8
    AST_PROT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        flag_prot && !flag_clr[0] |=> flag_prot); // R9
    AST_UNDEF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        flag_undef && !flag_clr[1] |=> flag_undef); // R9
endmodule

// File: rtl/prot_insn_check.sv
// Top: checks the redundant four-byte encoding of guarded system
// instructions, flags unimplemented opcodes and requests traps.
// Assumes one instruction per valid cycle; results appear one cycle later.
module prot_insn_check
    import prot_insn_pkg::*;
#(
    parameter int                ADDR_W         = 16,
    parameter logic [7:0]        CODE_WDOG_OFF  = 8'hA5,
    parameter logic [7:0]        CODE_WDOG_KICK = 8'hA7,
    parameter logic [7:0]        CODE_INIT_DONE = 8'hB5,
    parameter logic [7:0]        CODE_IDLE      = 8'h87,
    parameter logic [7:0]        CODE_SLEEP     = 8'h97,
    parameter logic [255:0]      UNDEF_MAP      = default_undef_map()
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ins_valid,
    input  logic [7:0]        ins_byte1,
    input  logic [7:0]        ins_byte2,
    input  logic [7:0]        ins_byte3,
    input  logic [7:0]        ins_byte4,
    input  logic [ADDR_W-1:0] ins_addr,
    input  logic [1:0]        flag_clr,
    output logic [5:0]        exec_en,
    output logic              trap_req,
    output logic [ADDR_W-1:0] trap_ret_addr,
    output logic              flag_prot,
    output logic              flag_undef
);
    localparam byte_t SWRESET_CODE = 8'hB7;
    localparam logic [PROT_NUM*BYTE_W-1:0] CODES =
        {CODE_SLEEP, CODE_IDLE, CODE_INIT_DONE, CODE_WDOG_KICK, CODE_WDOG_OFF, SWRESET_CODE};

    insn_word_t          word;
    logic [PROT_NUM-1:0] exec_vec;
    logic                prot_bad;
    logic                undef_op;

    // Pack the four byte ports into one instruction word.
    always_comb word = '{b1: ins_byte1, b2: ins_byte2, b3: ins_byte3, b4: ins_byte4};

    prot_opcode_class #(
        .NSLOT    (PROT_NUM),
        .CODES    (CODES),
        .UNDEF_MAP(UNDEF_MAP)
    ) i_class (
        .word    (word),
        .exec_vec(exec_vec),
        .prot_bad(prot_bad),
        .undef_op(undef_op)
    );

    prot_trap_regs #(
        .NSLOT (PROT_NUM),
        .ADDR_W(ADDR_W)
    ) i_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .ins_valid    (ins_valid),
        .exec_vec     (exec_vec),
        .prot_bad     (prot_bad),
        .undef_op     (undef_op),
        .ins_addr     (ins_addr),
        .flag_clr     (flag_clr),
        .exec_en      (exec_en),
        .trap_req     (trap_req),
        .trap_ret_addr(trap_ret_addr),
        .flag_prot    (flag_prot),
        .flag_undef   (flag_undef)
    );
endmodule

// File: tb/test_prot_insn_check.sv
module test_prot_insn_check;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ins_valid = 1'b0;
    logic [7:0]  b1 = '0, b2 = '0, b3 = '0, b4 = '0;
    logic [15:0] addr = '0;
    logic [1:0]  clr = '0;
    logic [5:0]  exec_en;
    logic        trap_req, flag_prot, flag_undef;
    logic [15:0] ret_addr;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    prot_insn_check i_prot_insn_check (
        .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid),
        .ins_byte1(b1), .ins_byte2(b2), .ins_byte3(b3), .ins_byte4(b4),
        .ins_addr(addr), .flag_clr(clr), .exec_en(exec_en), .trap_req(trap_req),
        .trap_ret_addr(ret_addr), .flag_prot(flag_prot), .flag_undef(flag_undef)
    );

    // {b1,b2,b3,b4,addr,exec,trap,prot,undef}
    localparam int NV = 13;
    localparam logic [56:0] VEC [NV] = '{
        {8'hB7, 8'h48, 8'hB7, 8'hB7, 16'h0100, 6'b000001, 3'b000}, // R2
        {8'hA5, 8'h5A, 8'hA5, 8'hA5, 16'h0104, 6'b000010, 3'b000}, // R1
        {8'hA7, 8'h58, 8'hA7, 8'hA7, 16'h0108, 6'b000100, 3'b000}, // R1
        {8'hB5, 8'h4A, 8'hB5, 8'hB5, 16'h010C, 6'b001000, 3'b000}, // R1
        {8'h87, 8'h78, 8'h87, 8'h87, 16'h0110, 6'b010000, 3'b000}, // R1
        {8'h97, 8'h68, 8'h97, 8'h97, 16'h0114, 6'b100000, 3'b000}, // R1
        {8'hB7, 8'h49, 8'hB7, 8'hB7, 16'h0200, 6'b000000, 3'b110}, // R3
        {8'hB7, 8'h48, 8'hB6, 8'hB7, 16'h0204, 6'b000000, 3'b110}, // R4
        {8'hA7, 8'h58, 8'hA7, 8'h37, 16'h0208, 6'b000000, 3'b110}, // R4
        {8'h8F, 8'h00, 8'h00, 8'h00, 16'h0300, 6'b000000, 3'b101}, // R6
        {8'hFF, 8'h00, 8'hFF, 8'hFF, 16'h0304, 6'b000000, 3'b101}, // R6
        {8'h12, 8'hED, 8'h12, 8'h12, 16'h0400, 6'b000000, 3'b000}, // R7
        {8'h7F, 8'h80, 8'h7F, 8'h7F, 16'h0404, 6'b000000, 3'b000}  // R7
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [7:0] x1, x2, x3, x4, input logic [15:0] a);
        b1 = x1; b2 = x2; b3 = x3; b4 = x4; addr = a; ins_valid = 1'b1;
    endtask

    task automatic clear_all();
        @(negedge clk); ins_valid = 1'b0; clr = 2'b11;
        @(negedge clk); clr = 2'b00;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R10 exec", {26'd0, exec_en}, 32'd0);
        chk("R10 trap/flags", {29'd0, trap_req, flag_prot, flag_undef}, 32'd0);
        chk("R10 ret", {16'd0, ret_addr}, 32'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            clear_all();
            drive(VEC[i][56:49], VEC[i][48:41], VEC[i][40:33], VEC[i][32:25], VEC[i][24:9]);
            @(negedge clk);
            chk($sformatf("R1/R7 vec%0d exec", i), {26'd0, exec_en}, {26'd0, VEC[i][8:3]});
            chk($sformatf("R3/R6 vec%0d trap", i), {31'd0, trap_req}, {31'd0, VEC[i][2]});
            chk($sformatf("R4/R6 vec%0d flags", i), {30'd0, flag_prot, flag_undef}, {30'd0, VEC[i][1:0]});
            if (VEC[i][2]) chk($sformatf("R5 vec%0d ret", i), {16'd0, ret_addr}, {16'd0, VEC[i][24:9]});
            ins_valid = 1'b0;
            @(negedge clk);
            chk($sformatf("R1 vec%0d pulse ends", i), {25'd0, exec_en, trap_req}, 32'd0);
        end

        // R8: broken pattern with valid low changes nothing
        clear_all();
        b1 = 8'hB7; b2 = 8'h00; b3 = 8'h8F; b4 = 8'h00; addr = 16'hBEEF;
        repeat (3) @(negedge clk);
        chk("R8 idle outputs", {25'd0, exec_en, trap_req}, 32'd0);
        chk("R8 idle flags", {30'd0, flag_prot, flag_undef}, 32'd0);
        chk("R8 idle ret", {16'd0, ret_addr}, {16'd0, 16'h0304});

        // R9: stickiness and selective clear
        drive(8'hB7, 8'h00, 8'hB7, 8'hB7, 16'h0500);
        @(negedge clk); ins_valid = 1'b0;
        drive(8'hEF, 8'h00, 8'h00, 8'h00, 16'h0504);
        @(negedge clk); ins_valid = 1'b0;
        chk("R5 latest ret", {16'd0, ret_addr}, {16'd0, 16'h0504});
        repeat (4) @(negedge clk);
        chk("R9 both sticky", {30'd0, flag_prot, flag_undef}, 32'd3);
        clr = 2'b01;
        @(negedge clk); clr = 2'b00;
        chk("R9 clear bit0 only", {30'd0, flag_prot, flag_undef}, 32'd1);
        clr = 2'b10;
        @(negedge clk); clr = 2'b00;
        chk("R9 clear bit1", {30'd0, flag_prot, flag_undef}, 32'd0);

        // R9: set wins over same-cycle clear
        drive(8'h97, 8'h68, 8'h97, 8'h96, 16'h0600);
        clr = 2'b01;
        @(negedge clk); ins_valid = 1'b0; clr = 2'b00;
        chk("R9 set beats clear", {31'd0, flag_prot}, 32'd1);

        // R5: good instruction after a trap leaves ret address alone
        drive(8'h87, 8'h78, 8'h87, 8'h87, 16'h0700);
        @(negedge clk); ins_valid = 1'b0;
        chk("R1 idle exec", {26'd0, exec_en}, 32'h10);
        chk("R5 ret held", {16'd0, ret_addr}, {16'd0, 16'h0600});

        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end
endmodule